// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block carries out one operation on one chosen bit of a byte, for use inside a processor
execute stage. A byte is presented together with a bit index, an operation code, the current carry
flag and the current zero flag. One clock later the unit returns four results:

- the possibly updated byte;
- a write-back enable that says whether the byte must be stored;
- the new carry flag;
- the new zero flag.

The unit works as a one-bit boolean processor built around the carry flag. Some operations edit the
chosen bit in place: set, clear and invert. One operation only tests the bit. Others move the bit
into carry or move carry into the bit, each with a plain and an inverted form. The remaining
operations combine the bit with carry through AND, OR or XOR, also with inverted forms. The caller
is responsible for fetching the operand and for storing the byte afterwards. The negative and
overflow flags are not inputs or outputs of this block, so no operation here can change them.

Top module: `bitop_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, out_valid, byte_out, wb_en, carry_out and zero_out are all zero.
- R2: The selected bit is bit number bit_sel, counted from the least significant bit as 0. Opcodes 0 (set), 1 (clear) and 2 (invert) force that bit to 1, force it to 0, or flip it. The other bits are unchanged, and wb_en is 1.
- R3: Opcode 3 (test) gives wb_en 0 and sets zero_out to the complement of the selected bit. carry_out is left equal to carry_in and byte_out equal to byte_in.
- R4: Opcode 4 (load) copies the selected bit into carry_out. Opcode 5 (inverted load) copies its complement. Both give wb_en 0 and leave the byte unchanged.
- R5: Opcode 6 (store) writes carry_in into the selected bit. Opcode 7 (inverted store) writes the complement of carry_in. The other bits are unchanged, and wb_en is 1.
- R6: The logic operations place their result in carry_out, give wb_en 0 and leave the byte unchanged. Opcode 8 gives bit AND carry_in, 10 gives bit OR carry_in and 12 gives bit XOR carry_in. Opcodes 9, 11 and 13 give the complement of those same results.
- R7: zero_out equals zero_in for every opcode except 3. carry_out equals carry_in for opcodes 0, 1, 2, 3, 6 and 7.
- R8: Results appear one clock after a cycle with in_valid high, with out_valid 1. After a cycle with in_valid low, out_valid and wb_en are 0, while byte_out, carry_out and zero_out keep their previous values.
- R9: The reserved opcodes 14 and 15 give out_valid 1, wb_en 0, byte_out equal to byte_in, carry_out equal to carry_in and zero_out equal to zero_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select, encoding as in R2 to R9 |
| bit_sel | input | 3 | Index of the bit to operate on |
| byte_in | input | 8 | Operand byte |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Results valid |
| byte_out | output | 8 | Resulting byte |
| wb_en | output | 1 | Byte must be written back |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | New zero flag |

## Verification
The assertions assume that op_code, bit_sel, byte_in, carry_in and zero_in carry known values whenever in_valid is high. They also assume these inputs change only between clock edges. The bench drives every input on the falling edge, always from defined random or directed values, and it keeps in_valid low during reset. The random stimulus covers all sixteen opcodes, including the reserved ones, with about a fifth of the cycles left idle. The directed cases cover bits 0 and 7, both carry values, and all-ones and all-zeros bytes.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        BOP_SET  = 4'd0,
        BOP_CLR  = 4'd1,
        BOP_INV  = 4'd2,
        BOP_TST  = 4'd3,
        BOP_LD   = 4'd4,
        BOP_ILD  = 4'd5,
        BOP_ST   = 4'd6,
        BOP_IST  = 4'd7,
        BOP_AND  = 4'd8,
        BOP_IAND = 4'd9,
        BOP_OR   = 4'd10,
        BOP_IOR  = 4'd11,
        BOP_XOR  = 4'd12,
        BOP_IXOR = 4'd13,
        BOP_RS0  = 4'd14,
        BOP_RS1  = 4'd15
    } bitop_e;

endpackage

// File: rtl/bitop_mask_dec.sv
module bitop_mask_dec #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  sel,
    output logic [DATA_W-1:0] mask
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign mask[i] = (sel == IDX_W'(i));
    end

    always_comb begin
        assert ($onehot0(mask)); // R2
    end

endmodule

// File: rtl/bitop_eval.sv
module bitop_eval
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] mask,
    input  bitop_e            op,
    input  logic              c_in,
    input  logic              z_in,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output logic              c_res,
    output logic              z_res
);

    logic picked;
    logic [DATA_W-1:0] cleared;

    assign picked  = |(opnd & mask);
    assign cleared = opnd & ~mask;

    always_comb begin
        res   = opnd;
        wr    = 1'b0;
        c_res = c_in;
        z_res = z_in;
        unique case (op)
            BOP_SET:  begin res = opnd | mask;  wr = 1'b1; end
            BOP_CLR:  begin res = cleared;      wr = 1'b1; end
            BOP_INV:  begin res = opnd ^ mask;  wr = 1'b1; end
            BOP_TST:  z_res = ~picked;
            BOP_LD:   c_res = picked;
            BOP_ILD:  c_res = ~picked;
            BOP_ST:   begin res = c_in  ? (cleared | mask) : cleared; wr = 1'b1; end
            BOP_IST:  begin res = !c_in ? (cleared | mask) : cleared; wr = 1'b1; end
            BOP_AND:  c_res = picked & c_in;
            BOP_IAND: c_res = ~(picked & c_in);
            BOP_OR:   c_res = picked | c_in;
            BOP_IOR:  c_res = ~(picked | c_in);
            BOP_XOR:  c_res = picked ^ c_in;
            BOP_IXOR: c_res = ~(picked ^ c_in);
            default:  ;
        endcase
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              carry_in,
    input  logic              zero_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] byte_out,
    output logic              wb_en,
    output logic              carry_out,
    output logic              zero_out
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              wr;
        logic              c;
        logic              z;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] ev_res;
    logic              ev_wr, ev_c, ev_z;

    bitop_mask_dec #(.DATA_W(DATA_W)) u_mask (
        .sel  (bit_sel),
        .mask (mask)
    );

    bitop_eval #(.DATA_W(DATA_W)) u_eval (
        .opnd  (byte_in),
        .mask  (mask),
        .op    (bitop_e'(op_code)),
        .c_in  (carry_in),
        .z_in  (zero_in),
        .res   (ev_res),
        .wr    (ev_wr),
        .c_res (ev_c),
        .z_res (ev_z)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.wr  = 1'b0;
        if (in_valid) begin
            st_d.vld  = 1'b1;
            st_d.data = ev_res;
            st_d.wr   = ev_wr;
            st_d.c    = ev_c;
            st_d.z    = ev_z;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign byte_out  = st_q.data;
    assign wb_en     = st_q.wr;
    assign carry_out = st_q.c;
    assign zero_out  = st_q.z;

    AST_ONE_BIT_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones(byte_out ^ $past(byte_in)) <= 1); // R2
    AST_TEST_ZFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'd3) |=> (!wb_en && zero_out == !$past(byte_in[bit_sel]))); // R3
    AST_LOGIC_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code >= 4'd8) |=> (!wb_en && byte_out == $past(byte_in))); // R6
    AST_EDIT_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code <= 4'd3) |=> carry_out == $past(carry_in)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid) |=> (!out_valid && !wb_en && $stable(byte_out)
                                      && $stable(carry_out) && $stable(zero_out))); // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] byte_in = '0;
    logic       carry_in = 1'b0;
    logic       zero_in = 1'b0;
    logic       out_valid, wb_en, carry_out, zero_out;
    logic [7:0] byte_out;

    int total = 0;
    int bad = 0;
    logic [11:0] last_obs;

    always #5 clk = ~clk;

    bitop_unit u_bitop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .bit_sel(bit_sel), .byte_in(byte_in), .carry_in(carry_in), .zero_in(zero_in),
        .out_valid(out_valid), .byte_out(byte_out), .wb_en(wb_en),
        .carry_out(carry_out), .zero_out(zero_out)
    );

    // expected {valid, byte, wb, c, z}
    function automatic logic [11:0] model(input logic [3:0] op, input logic [2:0] s,
                                          input logic [7:0] b, input logic c, input logic z);
        logic [7:0] nb;
        logic w, nc, nz, bt;
        nb = b; w = 1'b0; nc = c; nz = z; bt = b[s];
        case (op)
            4'd0:  begin nb[s] = 1'b1; w = 1'b1; end
            4'd1:  begin nb[s] = 1'b0; w = 1'b1; end
            4'd2:  begin nb[s] = ~bt;  w = 1'b1; end
            4'd3:  nz = ~bt;
            4'd4:  nc = bt;
            4'd5:  nc = ~bt;
            4'd6:  begin nb[s] = c;  w = 1'b1; end
            4'd7:  begin nb[s] = ~c; w = 1'b1; end
            4'd8:  nc = bt & c;
            4'd9:  nc = ~(bt & c);
            4'd10: nc = bt | c;
            4'd11: nc = ~(bt | c);
            4'd12: nc = bt ^ c;
            4'd13: nc = ~(bt ^ c);
            default: ;
        endcase
        return {1'b1, nb, w, nc, nz};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd2) return "R2";
        if (op == 4'd3) return "R3";
        if (op <= 4'd5) return "R4";
        if (op <= 4'd7) return "R5";
        if (op <= 4'd13) return "R6";
        return "R9";
    endfunction

    function automatic logic [11:0] observe();
        return {out_valid, byte_out, wb_en, carry_out, zero_out};
    endfunction

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [2:0] s, input logic [7:0] b,
                          input logic c, input logic z, input string req);
        logic [11:0] exp;
        exp = model(op, s, b, c, z);
        in_valid = 1'b1; op_code = op; bit_sel = s; byte_in = b; carry_in = c; zero_in = z;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, observe(), exp);
        last_obs = observe();
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        byte_in = 8'($urandom); carry_in = 1'($urandom); zero_in = 1'($urandom);
        op_code = 4'($urandom);
        @(negedge clk);
        check("R8", observe(), {1'b0, last_obs[10:3], 1'b0, last_obs[1:0]});
        last_obs = observe();
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", observe(), 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", observe(), 12'h000);
        last_obs = observe();

        // directed corners
        run_op(4'd0, 3'd7, 8'h00, 1'b0, 1'b0, "R2");
        run_op(4'd1, 3'd0, 8'hFF, 1'b1, 1'b1, "R2");
        run_op(4'd2, 3'd3, 8'hA5, 1'b0, 1'b0, "R2");
        run_op(4'd3, 3'd0, 8'hFE, 1'b1, 1'b0, "R3");
        run_op(4'd3, 3'd7, 8'h80, 1'b0, 1'b1, "R3");
        run_op(4'd4, 3'd7, 8'h80, 1'b0, 1'b0, "R4");
        run_op(4'd5, 3'd7, 8'h80, 1'b1, 1'b0, "R4");
        run_op(4'd6, 3'd5, 8'h00, 1'b1, 1'b0, "R5");
        run_op(4'd7, 3'd5, 8'hFF, 1'b1, 1'b0, "R5");
        run_op(4'd9, 3'd1, 8'h02, 1'b1, 1'b0, "R6");
        run_op(4'd11, 3'd1, 8'h00, 1'b0, 1'b1, "R6");
        run_op(4'd12, 3'd6, 8'h40, 1'b1, 1'b1, "R6");
        run_op(4'd13, 3'd6, 8'h40, 1'b1, 1'b0, "R6");
        run_op(4'd0, 3'd2, 8'h11, 1'b1, 1'b1, "R7");
        run_op(4'd14, 3'd4, 8'h3C, 1'b1, 1'b1, "R9");
        run_op(4'd15, 3'd4, 8'hC3, 1'b0, 1'b1, "R9");
        idle_cycle();
        idle_cycle();

        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(4, 0) == 0) idle_cycle();
            else begin
                logic [3:0] op;
                op = 4'($urandom);
                run_op(op, 3'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), tag_of(op));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule